// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block collects the interrupt sources of a UART, qualifies each one with its enable bit, and produces a single interrupt line and an 8-bit identification byte. Software reads that byte to learn which condition to service first. The block holds a pending flag for each source. Each flag is set by an event or a level from a detector outside the block. It is cleared by the register access that services that source: reading the line status, reading the modem status, reading the receive buffer, writing the holding register, or reading the identification byte while it reports transmit-empty.

When several sources are pending and enabled, only the most urgent one is reported. The order is line status, then received data, then character timeout, then transmit-empty, then modem status. Bits 7:6 of the identification byte tell software whether the FIFOs are switched on. The FIFOs, the timeout counter and the detectors themselves are outside this block. All block inputs are plain control and status pins, so the block has no valid/ready handshake.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset no source is pending, `irq` is 0 and `iir` reads 0x01 while `fifo_en` is 0.
- R2: `ier[0]` gates both received-data and timeout, `ier[1]` gates transmit-empty, `ier[2]` gates line status and `ier[3]` gates modem status. A pending source whose enable bit is 0 never raises `irq` and is never reported.
- R3: `iir[3:1]` reports the source with these codes: 011 line status, 010 received data, 110 character timeout, 001 transmit-empty, 000 modem status. `iir[5:4]` always read 00.
- R4: When several enabled sources are pending, the order is line status first, then received data, then timeout, then transmit-empty, then modem status. Only the highest is reported.
- R5: `iir[0]` is 0 when any enabled source is pending and 1 otherwise. `irq` is high exactly when an enabled source is pending.
- R6: `iir[7:6]` read 11 while `fifo_en` is 1 and 00 while it is 0.
- R7: The received-data condition depends on `fifo_en`. With `fifo_en` at 1 it holds when `rx_level` is at least the trigger level. For a 16-deep FIFO, `trig_sel` 00, 01, 10 and 11 select 1, 4, 8 and 14, and other depths scale by DEPTH/16. With `fifo_en` at 0 it holds when `rx_level` is nonzero. The flag follows this condition one cycle later, and it is forced to 0 for the cycle after an `rbr_rd`.
- R8: The timeout flag is set one cycle after `timeout_evt` and cleared one cycle after `rbr_rd`. An event in the same cycle as the read wins.
- R9: The line-status flag is set by `lsr_err_evt` and cleared by `lsr_rd`. The modem flag is set by `msr_change` and cleared by `msr_rd`. Each flag updates one cycle later, and an event wins over a clear in the same cycle.
- R10: The transmit-empty flag is set on a rising edge of `thr_empty`, or on a rising edge of `ier[1]` while `thr_empty` is 1. It is cleared by `thr_wr`, or by `iir_rd` in a cycle where `iir[3:1]` is 001 with `iir[0]` at 0. A set in the same cycle wins.
- R11: `irq` and `iir` follow changes of `ier` and `fifo_en` in the same cycle, without a register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier | input | 4 | Source enable bits |
| fifo_en | input | 1 | FIFOs switched on |
| trig_sel | input | 2 | Receive trigger level select |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill count |
| lsr_err_evt | input | 1 | Line error event pulse |
| timeout_evt | input | 1 | Character timeout event pulse |
| thr_empty | input | 1 | Holding stage empty level |
| msr_change | input | 1 | Modem line change event pulse |
| iir_rd | input | 1 | Identification byte read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| irq | output | 1 | Interrupt request |
| iir | output | 8 | Identification byte |

## Verification
Directed cases raise one source at a time under a single enable bit. This separates the code table and the enable gating from the priority logic. Pairs of sources are then raised together to expose an ordering fault. The trigger levels are walked across their thresholds with the FIFOs on and off, which shows whether the comparison is inclusive and whether the non-FIFO rule is used. Long random runs mix events, strobes, enable changes and level changes, including a set and a clear in the same cycle and identification reads while transmit-empty is reported. These runs are checked every cycle against a reference model and catch faults in set/clear precedence and in the acknowledge-by-read path.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ID_MODEM   = 3'b000,
    ID_THRE    = 3'b001,
    ID_RXDATA  = 3'b010,
    ID_LINE    = 3'b011,
    ID_TIMEOUT = 3'b110
  } irq_id_e;

  typedef struct packed {
    logic line;
    logic rxd;
    logic tmo;
    logic thre;
    logic modem;
  } pend_t;

  // Trigger level for a FIFO of the given depth, scaled from a 16-entry base.
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned depth);
    int unsigned unit;
    unit = depth / 16;
    if (unit == 0) unit = 1;
    case (sel)
      2'b00:   return unit;
      2'b01:   return 4 * unit;
      2'b10:   return 8 * unit;
      default: return 14 * unit;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] rx_level,
  input  logic          thre_en,
  input  logic          thr_empty,
  input  logic          lsr_err_evt,
  input  logic          timeout_evt,
  input  logic          msr_change,
  input  logic          rbr_rd,
  input  logic          lsr_rd,
  input  logic          msr_rd,
  input  logic          thr_wr,
  input  logic          thre_ack,
  output pend_t         pend_o
);

  logic [LW-1:0] trig_lvl;
  logic          rxd_cond;
  logic          thr_empty_q;
  logic          thre_en_q;
  logic          thre_set;
  logic          thre_clr;

  always_comb begin
    trig_lvl = LW'(trig_level(trig_sel, DEPTH));
    rxd_cond = fifo_en ? (rx_level >= trig_lvl) : (rx_level != '0);
    thre_set = (thr_empty && !thr_empty_q) || (thre_en && !thre_en_q && thr_empty);
    thre_clr = thr_wr || thre_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o      <= '0;
      thr_empty_q <= 1'b0;
      thre_en_q   <= 1'b0;
    end else begin
      thr_empty_q  <= thr_empty;
      thre_en_q    <= thre_en;
      pend_o.line  <= lsr_err_evt || (pend_o.line && !lsr_rd);
      pend_o.modem <= msr_change || (pend_o.modem && !msr_rd);
      pend_o.tmo   <= timeout_evt || (pend_o.tmo && !rbr_rd);
      pend_o.rxd   <= rxd_cond && !rbr_rd;
      pend_o.thre  <= thre_set || (pend_o.thre && !thre_clr);
    end
  end

  // R9
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !lsr_err_evt) |=> !pend_o.line);

  // R9
  modem_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msr_change |=> pend_o.modem);

  // R8
  tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> pend_o.tmo);

  // R10
  thre_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_empty) |=> pend_o.thre);

  // R7
  rxd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_rd |=> !pend_o.rxd);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  pend_t      pend,
  input  logic [3:0] irq_en,
  output irq_id_e    id,
  output logic       active
);

  logic [4:0] req;

  always_comb begin
    req    = {pend.line  && irq_en[2],
              pend.rxd   && irq_en[0],
              pend.tmo   && irq_en[0],
              pend.thre  && irq_en[1],
              pend.modem && irq_en[3]};
    active = |req;
    if (req[4])      id = ID_LINE;
    else if (req[3]) id = ID_RXDATA;
    else if (req[2]) id = ID_TIMEOUT;
    else if (req[1]) id = ID_THRE;
    else             id = ID_MODEM;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ier,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] rx_level,
  input  logic          lsr_err_evt,
  input  logic          timeout_evt,
  input  logic          thr_empty,
  input  logic          msr_change,
  input  logic          iir_rd,
  input  logic          thr_wr,
  input  logic          rbr_rd,
  input  logic          lsr_rd,
  input  logic          msr_rd,
  output logic          irq,
  output logic [7:0]    iir
);

  pend_t   pend;
  irq_id_e id;
  logic    active;
  logic    thre_ack;

  assign thre_ack = iir_rd && active && (id == ID_THRE);

  uart_irq_sources #(.DEPTH(DEPTH)) u_src (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .rx_level(rx_level), .thre_en(ier[1]), .thr_empty(thr_empty),
    .lsr_err_evt(lsr_err_evt), .timeout_evt(timeout_evt),
    .msr_change(msr_change), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
    .msr_rd(msr_rd), .thr_wr(thr_wr), .thre_ack(thre_ack), .pend_o(pend)
  );

  uart_irq_prio u_prio (
    .pend(pend), .irq_en(ier), .id(id), .active(active)
  );

  assign irq = active;
  assign iir = {fifo_en ? 2'b11 : 2'b00, 2'b00, id, ~active};

  // R4
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend.line && ier[2]) |-> (iir[3:1] == 3'b011));

  // R2
  gated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'h0) |-> !irq);

  // R10
  thre_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && !iir[0] && iir[3:1] == 3'b001 && thr_empty && $past(thr_empty)
     && !($rose(ier[1]))) |=> !pend.thre);

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ier = 4'h0;
  logic fifo_en = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic [LW-1:0] rx_level = '0;
  logic lsr_err_evt = 0, timeout_evt = 0, thr_empty = 0, msr_change = 0;
  logic iir_rd = 0, thr_wr = 0, rbr_rd = 0, lsr_rd = 0, msr_rd = 0;
  logic irq;
  logic [7:0] iir;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_line, m_rxd, m_tmo, m_thre, m_modem, m_empty_q, m_en_q;

  always #2.5 clk = ~clk;

  uart_irq_ident #(.DEPTH(DEPTH)) i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ier(ier), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .rx_level(rx_level), .lsr_err_evt(lsr_err_evt), .timeout_evt(timeout_evt),
    .thr_empty(thr_empty), .msr_change(msr_change), .iir_rd(iir_rd),
    .thr_wr(thr_wr), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
    .irq(irq), .iir(iir)
  );

  function automatic int trig(input logic [1:0] s);
    case (s) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 14; endcase
  endfunction

  function automatic logic [7:0] exp_iir();
    logic [2:0] c;
    logic p;
    p = 1'b1;
    if (m_line && ier[2])       c = 3'b011;
    else if (m_rxd && ier[0])   c = 3'b010;
    else if (m_tmo && ier[0])   c = 3'b110;
    else if (m_thre && ier[1])  c = 3'b001;
    else if (m_modem && ier[3]) c = 3'b000;
    else begin c = 3'b000; p = 1'b0; end
    return {fifo_en ? 2'b11 : 2'b00, 2'b00, c, ~p};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    logic [7:0] e;
    e = exp_iir();
    check(req, iir, e);
    check(req, {7'd0, irq}, {7'd0, ~e[0]});
  endtask

  // Advance the reference by one clock using the inputs currently applied.
  task automatic model_step();
    logic [7:0] e;
    bit cond, tset;
    e = exp_iir();
    cond = fifo_en ? (int'(rx_level) >= trig(trig_sel)) : (rx_level != 0);
    tset = (thr_empty && !m_empty_q) || (ier[1] && !m_en_q && thr_empty);
    m_thre  = tset || (m_thre && !(thr_wr || (iir_rd && !e[0] && e[3:1] == 3'b001)));
    m_line  = lsr_err_evt || (m_line && !lsr_rd);
    m_modem = msr_change || (m_modem && !msr_rd);
    m_tmo   = timeout_evt || (m_tmo && !rbr_rd);
    m_rxd   = cond && !rbr_rd;
    m_empty_q = thr_empty;
    m_en_q    = ier[1];
  endtask

  task automatic cyc(input string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_out(req);
    {lsr_err_evt, timeout_evt, msr_change, iir_rd, thr_wr, rbr_rd, lsr_rd, msr_rd} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", iir, 8'h01);
    check("R1", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    cyc("R1");
    check("R1", iir, 8'h01);

    // R9 line status, R3 code 011, R2 gating
    lsr_err_evt = 1; cyc("R2");
    check("R2", {7'd0, irq}, 8'h00);
    ier = 4'b0100; #0 check("R11", iir, 8'h07 - 8'h01);
    lsr_rd = 1; cyc("R9");
    check("R9", iir, 8'h01);
    // R9 set wins over clear
    lsr_err_evt = 1; lsr_rd = 1; cyc("R9");
    check("R9", iir, 8'h06);
    lsr_rd = 1; cyc("R9");

    // R6 FIFO status bits
    fifo_en = 1; #0 check("R6", iir, 8'hC1);

    // R7 trigger threshold: 4 needed for sel 01
    ier = 4'b0001; trig_sel = 2'b01; rx_level = LW'(3); cyc("R7");
    check("R7", iir, 8'hC1);
    rx_level = LW'(4); cyc("R7");
    check("R7", iir, 8'hC4);
    trig_sel = 2'b11; rx_level = LW'(13); cyc("R7");
    check("R7", iir, 8'hC1);
    rx_level = LW'(14); cyc("R7");
    rbr_rd = 1; cyc("R7");
    check("R7", iir, 8'hC1);
    fifo_en = 0; rx_level = LW'(1); cyc("R7");
    check("R7", iir, 8'h04);
    rx_level = '0; cyc("R7");

    // R8 timeout code 110
    timeout_evt = 1; cyc("R8");
    check("R8", iir, 8'h0C);
    rbr_rd = 1; cyc("R8");
    check("R8", iir, 8'h01);

    // R4 priority: line over rx data, rx data over timeout
    ier = 4'hF; rx_level = LW'(2); timeout_evt = 1; lsr_err_evt = 1; cyc("R4");
    check("R4", iir, 8'h06);
    lsr_rd = 1; cyc("R4");
    check("R4", iir, 8'h04);
    rx_level = '0; cyc("R4");
    check("R4", iir, 8'h0C);
    rbr_rd = 1; cyc("R4");

    // R10 transmit-empty, cleared by identification read
    thr_empty = 1; cyc("R10");
    check("R10", iir, 8'h02);
    msr_change = 1; cyc("R4");
    check("R4", iir, 8'h02);
    iir_rd = 1; cyc("R10");
    check("R10", iir, 8'h00);
    msr_rd = 1; cyc("R9");
    check("R5", iir, 8'h01);
    // R10 rising enable while empty
    ier = 4'b0000; cyc("R10");
    ier = 4'b0010; cyc("R10");
    check("R10", iir, 8'h02);
    thr_wr = 1; thr_empty = 0; cyc("R10");
    check("R10", iir, 8'h01);

    // Random mix, compared each cycle against the reference
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) ier = 4'($urandom);
      if ($urandom_range(0, 31) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 15) == 0) trig_sel = 2'($urandom);
      if ($urandom_range(0, 3) == 0) rx_level = LW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 7) == 0) thr_empty = ~thr_empty;
      lsr_err_evt = ($urandom_range(0, 15) == 0);
      timeout_evt = ($urandom_range(0, 15) == 0);
      msr_change  = ($urandom_range(0, 15) == 0);
      iir_rd = ($urandom_range(0, 3) == 0);
      thr_wr = ($urandom_range(0, 7) == 0);
      rbr_rd = ($urandom_range(0, 7) == 0);
      lsr_rd = ($urandom_range(0, 7) == 0);
      msr_rd = ($urandom_range(0, 7) == 0);
      cyc("R4");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule